// File: doc/BRIEF.md
# Overlapping Four-Bit Pattern Detector

This block watches a serial bit stream, one bit per rising clock edge. It raises a single flag in the same cycle as the bit that completes either of two mirrored four-bit windows: two zeros then two ones, or two ones then two zeros. The flag is a Mealy output. It depends on the stored history and on the bit currently present at the input, so it is valid before the edge that samples that bit.

Matches may share bits. A stream such as 0,0,1,1,0,0 flags twice. History is not held as a raw four-bit shift register. It is held as a minimised summary of the last three bits, with six reachable states. The two spare codes of the three-bit state register lead back into used states.

An asynchronous active-low reset returns the machine to its initial state. Release of that reset is synchronised to the clock. A short warm-up counter keeps the flag low until the current bit is the fourth bit sampled since reset, so a window is never completed with bits that were not received.

Top module: `pattern_det`

## Requirements
- R1: `z_out` is 1 while the three most recently sampled bits are 0,0,1 (oldest first) and `x_in` is 1.
- R2: `z_out` is 1 while the three most recently sampled bits are 1,1,0 and `x_in` is 0.
- R3: For every other four-bit window (three sampled bits plus the current `x_in`), `z_out` is 0.
- R4: Detections overlap. The stream 0,0,1,1,0,0,1,1 flags on its 4th, 6th and 8th bits. After a 0011 match, the state is the one that holds "last two bits were 1".
- R5: The output is Mealy. Changing `x_in` between clock edges changes `z_out` in the same cycle, without waiting for an edge.
- R6: `z_out` stays 0 unless at least three bits have been sampled since reset release. For example, 1,1 right after reset gives no flag, and 0,0,1,1 right after reset flags on its 4th bit.
- R7: The state register takes only the six codes 000 (ends x00), 001 (ends 001), 011 (ends 010), 010 (ends x11), 110 (ends 101) and 111 (ends 110). Spare code 100 goes to 000 on 0 and to 001 on 1. Spare code 101 goes to 011 on 0 and to 010 on 1.
- R8: Driving `rst_n` low forces `z_out` to 0 at once and puts the state in 000. After `rst_n` rises, the first bit is sampled on the third rising clock edge.
- R9: Over any long stream, `z_out` agrees on every cycle with a four-bit shift-register comparison that follows R1 to R3 and R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| x_in | input | 1 | Serial data bit, sampled each rising edge |
| z_out | output | 1 | Match flag for the current four-bit window |

## Verification
A wrong state code or a wrong transition shows up as a missed or spurious flag. Because only three bits of history are kept, any such error reaches `z_out` within at most four sampled bits. The fixed vector table walks both patterns, their overlap and near-miss windows such as 0001 and 1110. A long pseudo-random stream then compares every cycle against a shift-register model. Changing `x_in` mid-cycle exposes a registered (non-Mealy) output immediately. The early-stream cases show whether the warm-up gating is off by one.

// File: rtl/pattern_det_pkg.sv
package pattern_det_pkg;

  // State codes: the name gives the three-bit history the state stands for.
  typedef enum logic [2:0] {
    ST_X00   = 3'b000,
    ST_H001  = 3'b001,
    ST_X11   = 3'b010,
    ST_H010  = 3'b011,
    ST_SPR_A = 3'b100,
    ST_SPR_B = 3'b101,
    ST_H101  = 3'b110,
    ST_H110  = 3'b111
  } pdet_state_e;

  localparam pdet_state_e ST_INIT = ST_X00;

endpackage

// File: rtl/pdet_reset_sync.sv
module pdet_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = sr_q[STAGES-1];

endmodule

// File: rtl/pdet_next_state.sv
module pdet_next_state
  import pattern_det_pkg::*;
(
  input  pdet_state_e state,
  input  logic        x_in,
  output pdet_state_e state_nxt,
  output logic        hit
);

  always_comb begin
    state_nxt = ST_INIT;
    hit       = 1'b0;
    case (state)
      ST_X00:   state_nxt = x_in ? ST_H001 : ST_X00;
      ST_H001: begin
        state_nxt = x_in ? ST_X11 : ST_H010;
        hit       = x_in;
      end
      ST_H010:  state_nxt = x_in ? ST_H101 : ST_X00;
      ST_X11:   state_nxt = x_in ? ST_X11 : ST_H110;
      ST_H101:  state_nxt = x_in ? ST_X11 : ST_H010;
      ST_H110: begin
        state_nxt = x_in ? ST_H101 : ST_X00;
        hit       = !x_in;
      end
      ST_SPR_A: state_nxt = x_in ? ST_H001 : ST_X00;
      ST_SPR_B: state_nxt = x_in ? ST_X11 : ST_H010;
      default:  state_nxt = ST_INIT;
    endcase
  end

endmodule

// File: rtl/pdet_warmup.sv
module pdet_warmup #(
  parameter int WIN_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic warm
);

  localparam int LIMIT = WIN_LEN - 1;
  localparam int CW    = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign warm   = (cnt_q == CW'(LIMIT));
  assign cnt_en = !warm;
  assign cnt_d  = cnt_q + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pattern_det.sv
module pattern_det
  import pattern_det_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WIN_LEN     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic x_in,
  output logic z_out
);

  logic        rst_sync_n;
  pdet_state_e state_q;
  pdet_state_e state_d;
  logic        hit_raw;
  logic        warm;

  pdet_reset_sync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pdet_next_state u_nsl (
    .state     (state_q),
    .x_in      (x_in),
    .state_nxt (state_d),
    .hit       (hit_raw)
  );

  pdet_warmup #(.WIN_LEN(WIN_LEN)) u_warm (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .warm  (warm)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_INIT;
    else             state_q <= state_d;
  end

  assign z_out = hit_raw && warm;

endmodule

// File: rtl/pattern_det_checker.sv
module pattern_det_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rst_int_n,
  input logic       x_in,
  input logic       z_out,
  input logic [2:0] state
);

  logic [2:0] hist_q;
  logic [1:0] seen_q;
  logic       win_hit;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      hist_q <= '0;
      seen_q <= '0;
    end else begin
      hist_q <= {hist_q[1:0], x_in};
      if (seen_q != 2'd3) seen_q <= seen_q + 2'd1;
    end
  end

  assign win_hit = ({hist_q, x_in} == 4'b0011) || ({hist_q, x_in} == 4'b1100);

  // R1 R2 R3 R9: flag equals independent window compare once warm
  assert_window_match_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (seen_q == 2'd3) |-> (z_out == win_hit));

  // R6: quiet until three bits seen
  assert_quiet_warmup_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (seen_q != 2'd3) |-> !z_out);

  // R7: spare codes never reached
  assert_no_spare_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state != 3'b100) && (state != 3'b101));

  // R5: flag comes from the 001 state on a 1 and the 110 state on a 0
  assert_mealy_src_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    z_out |-> ((x_in && state == 3'b001) || (!x_in && state == 3'b111)));

  // R4: after a 0011 match the machine remembers the trailing ones
  assert_overlap_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (z_out && x_in) |=> (state == 3'b010));

  // R8: held in the initial state while the internal reset is low
  assert_reset_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_int_n |=> (state == 3'b000));

endmodule

bind pattern_det pattern_det_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_int_n (rst_sync_n),
  .x_in      (x_in),
  .z_out     (z_out),
  .state     (state_q)
);

// File: tb/pattern_det_bench.sv
`timescale 1ns/1ps
module pattern_det_bench;

  localparam real HALF = 2.5;
  localparam int  NVEC = 16;
  localparam int  NRND = 3000;

  // {x, expected z}, applied from reset in order
  localparam logic [1:0] VEC [NVEC] = '{
    2'b00, 2'b00, 2'b10, 2'b11, 2'b00, 2'b01, 2'b10, 2'b11,
    2'b10, 2'b00, 2'b10, 2'b00, 2'b00, 2'b00, 2'b10, 2'b11
  };

  logic clk = 1'b0;
  logic rst_n;
  logic x_in;
  logic z_out;

  int         nvec = 0;
  int         nerr = 0;
  logic [2:0] hist;
  int         nsamp;

  pattern_det u_pattern_det (
    .clk   (clk),
    .rst_n (rst_n),
    .x_in  (x_in),
    .z_out (z_out)
  );

  always #(HALF) clk = ~clk;

  task automatic check(input logic act, input logic exp, input string tag);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: z_out=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic model_z(input logic b);
    return (nsamp >= 3) && (({hist, b} == 4'b0011) || ({hist, b} == 4'b1100));
  endfunction

  // Assert reset, release at a falling edge, then wait the two sync edges.
  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    x_in  = 1'b0;
    #1;
    check(z_out, 1'b0, "R8 reset forces z low");
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    hist  = '0;
    nsamp = 0;
  endtask

  task automatic apply_bit(input logic b, input bit use_exp, input logic exp, input string tag);
    @(negedge clk);
    x_in = b;
    #1;
    check(z_out, model_z(b), "R9 model compare");
    if (use_exp) check(z_out, exp, tag);
    @(posedge clk);
    hist = {hist[1:0], b};
    if (nsamp < 3) nsamp++;
  endtask

  initial begin
    #(2.0 * HALF * 200000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0;
    x_in  = 1'b0;
    hist  = '0;
    nsamp = 0;
    do_reset();

    // Table walk: R1 R2 R3 R4 R6
    for (int i = 0; i < NVEC; i++)
      apply_bit(VEC[i][1], 1'b1, VEC[i][0], "R1/R2/R3/R4 table");

    // R6: 1,1 right after reset must stay quiet; 1,1,0,0 flags on the 4th
    do_reset();
    apply_bit(1'b1, 1'b1, 1'b0, "R6 first bit");
    apply_bit(1'b1, 1'b1, 1'b0, "R6 early 11 no flag");
    apply_bit(1'b0, 1'b1, 1'b0, "R6 third bit");
    apply_bit(1'b0, 1'b1, 1'b1, "R2 1100 from reset");
    apply_bit(1'b1, 1'b1, 1'b0, "R3 1001");
    apply_bit(1'b1, 1'b1, 1'b1, "R4 0011 overlaps 1100");

    // R5: Mealy response to x within one cycle
    do_reset();
    apply_bit(1'b0, 1'b0, 1'b0, "");
    apply_bit(1'b0, 1'b0, 1'b0, "");
    apply_bit(1'b1, 1'b0, 1'b0, "");
    @(negedge clk);
    x_in = 1'b0;
    #1;
    check(z_out, 1'b0, "R5 0010 no flag");
    x_in = 1'b1;
    #1;
    check(z_out, 1'b1, "R5 same-cycle rise on x=1");
    x_in = 1'b0;
    #1;
    check(z_out, 1'b0, "R5 same-cycle fall on x=0");
    x_in = 1'b1;
    #1;
    @(posedge clk);
    hist = {hist[1:0], 1'b1};

    // R8: reset mid-stream while a match is pending on x
    @(negedge clk);
    x_in  = 1'b0;
    #1;
    check(z_out, 1'b0, "R3 0110 no flag");
    rst_n = 1'b0;
    #1;
    check(z_out, 1'b0, "R8 async reset clears flag");
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    x_in  = 1'b1;
    @(posedge clk);
    @(posedge clk);
    hist  = '0;
    nsamp = 0;
    // R8: first sample lands on the third edge; 0,0,1,1 then flags on bit 4
    apply_bit(1'b0, 1'b1, 1'b0, "R8 restart bit 1");
    apply_bit(1'b0, 1'b1, 1'b0, "R8 restart bit 2");
    apply_bit(1'b1, 1'b1, 1'b0, "R8 restart bit 3");
    apply_bit(1'b1, 1'b1, 1'b1, "R1 0011 after restart");
    apply_bit(1'b1, 1'b1, 1'b0, "R3 0111");
    apply_bit(1'b0, 1'b1, 1'b0, "R3 1110");
    apply_bit(1'b0, 1'b1, 1'b1, "R2 1100");

    // R9: long pseudo-random stream against the shift-register model
    lfsr = 16'hACE1;
    for (int i = 0; i < NRND; i++) begin
      apply_bit(lfsr[0] ^ lfsr[5], 1'b0, 1'b0, "");
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule